// File: doc/BRIEF.md
# Region-Gated Trace Buffer Stall Request

This block raises a stall request towards the processor core whenever the trace buffer is close to running out of free space. The request comes from a level comparison: the buffer reports how many bytes are still free, and when that figure drops strictly below a programmed level the block asks the core to pause. The request is then gated by an address region test. The test takes match vectors from a bank of memory map decoders and a bank of address range comparators. A pair of masks chooses which of those matches count as "the region".

A mode bit sets the polarity of the gate. In include mode the stall may be raised only while at least one selected match is active. In exclude mode the stall is blocked while any selected match is active, and it is allowed otherwise. Configuration is written through a narrow register port with two addresses: one for the region word and one for the level. The output is registered, so it follows its inputs with one cycle of delay.

Top module: `fifo_stall_gate`

## Requirements
- R1: While rst_ni is low, stall_o is 0. Reset clears the level to 0, clears both masks to 0 and selects include mode.
- R2: The level condition holds only when free_bytes_i is strictly less than the level. free_bytes_i equal to the level gives no stall.
- R3: With a level of 0, stall_o is never asserted, whatever the region inputs are.
- R4: In include mode (mode bit 0), stall_o requires the level condition and at least one decoder or range match whose mask bit is set.
- R5: In exclude mode (mode bit 1), stall_o requires the level condition and no decoder or range match whose mask bit is set.
- R6: A decoder or range match whose mask bit is clear has no effect on stall_o.
- R7: stall_o is registered. It reflects the free count, the match vectors and the configuration as they were at the previous rising clock edge.
- R8: A write with cfg_we_i high and cfg_addr_i = 0 loads the region word. Bits [15:0] are the decoder mask (bit n selects decoder n+1). Bits [23:16] are the range mask (bit 16+n selects comparator n+1). Bit 24 is the mode bit.
- R9: A write with cfg_we_i high and cfg_addr_i = 1 loads the level from bits [7:0]. Bits [24:8] are ignored.
- R10: While cfg_we_i is low, the configuration does not change, whatever cfg_addr_i and cfg_wdata_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| free_bytes_i | input | 8 | Free bytes left in the trace buffer |
| dec_match_i | input | 16 | Memory map decoder match vector; bit n is decoder n+1 |
| rng_match_i | input | 8 | Address range comparator match vector; bit n is comparator n+1 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | Configuration address: 0 selects the region word, 1 selects the level |
| cfg_wdata_i | input | 25 | Configuration write data |
| stall_o | output | 1 | Registered stall request |

## Verification
Bad state in the level, mask or mode registers does not show up on its own. It shows up on stall_o only when the free count and the match vectors expose it, which happens one cycle after those inputs are applied. For that reason the bench mixes free counts on both sides of the level, including the equal case, with match vectors that hit selected and unselected positions in both modes. A swapped mask bit, an inverted mode or an off-by-one comparison therefore produces a wrong stall_o within a few cycles. Writes with the strobe low are followed by stimulus that would behave differently if the configuration had changed.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic {
    CFG_REGION = 1'b0,
    CFG_LEVEL  = 1'b1
  } cfg_sel_e;

  typedef enum logic {
    GATE_INCLUDE = 1'b0,
    GATE_EXCLUDE = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/fsg_cfg_regs.sv
module fsg_cfg_regs #(
  parameter int DEC_N = 16,
  parameter int RNG_N = 8,
  parameter int LVL_W = 8,
  localparam int CFG_W = DEC_N + RNG_N + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                addr_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output logic [LVL_W-1:0]    level_o,
  output logic [DEC_N-1:0]    dec_mask_o,
  output logic [RNG_N-1:0]    rng_mask_o,
  output fsg_pkg::gate_mode_e mode_o
);
  import fsg_pkg::*;

  localparam int RNG_LSB  = DEC_N;
  localparam int MODE_BIT = DEC_N + RNG_N;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o    <= '0;
      dec_mask_o <= '0;
      rng_mask_o <= '0;
      mode_o     <= GATE_INCLUDE;
    end else if (we_i) begin
      if (cfg_sel_e'(addr_i) == CFG_LEVEL) begin
        level_o <= wdata_i[LVL_W-1:0];
      end else begin
        dec_mask_o <= wdata_i[DEC_N-1:0];
        rng_mask_o <= wdata_i[RNG_LSB +: RNG_N];
        mode_o     <= gate_mode_e'(wdata_i[MODE_BIT]);
      end
    end
  end
endmodule

// File: rtl/fsg_region.sv
module fsg_region #(
  parameter int DEC_N = 16,
  parameter int RNG_N = 8
) (
  input  logic [DEC_N-1:0]    dec_match_i,
  input  logic [DEC_N-1:0]    dec_mask_i,
  input  logic [RNG_N-1:0]    rng_match_i,
  input  logic [RNG_N-1:0]    rng_mask_i,
  input  fsg_pkg::gate_mode_e mode_i,
  output logic                permit_o
);
  import fsg_pkg::*;

  localparam int SRC_N = DEC_N + RNG_N;

  logic [SRC_N-1:0] sel_hit;
  logic             hit;

  // one qualified hit per source, decoders in the low lanes
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    if (i < DEC_N) begin : g_dec
      assign sel_hit[i] = dec_match_i[i] & dec_mask_i[i];
    end else begin : g_rng
      assign sel_hit[i] = rng_match_i[i-DEC_N] & rng_mask_i[i-DEC_N];
    end
  end

  assign hit      = |sel_hit;
  assign permit_o = (mode_i == GATE_EXCLUDE) ? ~hit : hit;
endmodule

// File: rtl/fsg_thresh.sv
module fsg_thresh #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] free_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             low_o
);
  assign low_o = free_i < level_i;
endmodule

// File: rtl/fifo_stall_gate.sv
module fifo_stall_gate #(
  parameter int DEC_N = 16,
  parameter int RNG_N = 8,
  parameter int LVL_W = 8,
  localparam int CFG_W = DEC_N + RNG_N + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] free_bytes_i,
  input  logic [DEC_N-1:0] dec_match_i,
  input  logic [RNG_N-1:0] rng_match_i,
  input  logic             cfg_we_i,
  input  logic             cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             stall_o
);
  import fsg_pkg::*;

  logic [LVL_W-1:0] level_q;
  logic [DEC_N-1:0] dec_mask_q;
  logic [RNG_N-1:0] rng_mask_q;
  gate_mode_e       mode_q;
  logic             permit;
  logic             low;
  logic             stall_q;

  fsg_cfg_regs #(.DEC_N(DEC_N), .RNG_N(RNG_N), .LVL_W(LVL_W)) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .level_o    (level_q),
    .dec_mask_o (dec_mask_q),
    .rng_mask_o (rng_mask_q),
    .mode_o     (mode_q)
  );

  fsg_region #(.DEC_N(DEC_N), .RNG_N(RNG_N)) i_region (
    .dec_match_i (dec_match_i),
    .dec_mask_i  (dec_mask_q),
    .rng_match_i (rng_match_i),
    .rng_mask_i  (rng_mask_q),
    .mode_i      (mode_q),
    .permit_o    (permit)
  );

  fsg_thresh #(.LVL_W(LVL_W)) i_thresh (
    .free_i  (free_bytes_i),
    .level_i (level_q),
    .low_o   (low)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= low & permit;
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/fifo_stall_gate_chk.sv
module fifo_stall_gate_chk #(
  parameter int DEC_N = 16,
  parameter int RNG_N = 8,
  parameter int LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] free_bytes_i,
  input logic [DEC_N-1:0] dec_match_i,
  input logic [RNG_N-1:0] rng_match_i,
  input logic [LVL_W-1:0] level_q,
  input logic [DEC_N-1:0] dec_mask_q,
  input logic [RNG_N-1:0] rng_mask_q,
  input logic             mode_q,
  input logic             stall_o
);
  logic sel_hit;
  assign sel_hit = (|(dec_match_i & dec_mask_q)) | (|(rng_match_i & rng_mask_q));

  assert_reset_quiet_R1: assert property (@(posedge clk_i) !rst_ni |-> !stall_o);

  assert_strict_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> $past(free_bytes_i < level_q));

  assert_zero_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(level_q) == '0) |-> !stall_o);

  assert_include_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !$past(mode_q)) |-> $past(sel_hit));

  assert_exclude_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(mode_q)) |-> !$past(sel_hit));
endmodule

bind fifo_stall_gate fifo_stall_gate_chk #(.DEC_N(DEC_N), .RNG_N(RNG_N), .LVL_W(LVL_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .free_bytes_i (free_bytes_i),
  .dec_match_i  (dec_match_i),
  .rng_match_i  (rng_match_i),
  .level_q      (level_q),
  .dec_mask_q   (dec_mask_q),
  .rng_mask_q   (rng_mask_q),
  .mode_q       (mode_q),
  .stall_o      (stall_o)
);

// File: tb/test_fifo_stall_gate.sv
module test_fifo_stall_gate;
  localparam int CLK_PERIOD = 10;
  localparam int DEC_N = 16;
  localparam int RNG_N = 8;
  localparam int LVL_W = 8;
  localparam int CFG_W = DEC_N + RNG_N + 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [LVL_W-1:0] free_bytes_i = '0;
  logic [DEC_N-1:0] dec_match_i = '0;
  logic [RNG_N-1:0] rng_match_i = '0;
  logic             cfg_we_i = 1'b0;
  logic             cfg_addr_i = 1'b0;
  logic [CFG_W-1:0] cfg_wdata_i = '0;
  logic             stall_o;

  int n_checks = 0;
  int n_fail = 0;

  // bench model of configuration
  logic [LVL_W-1:0] m_level = '0;
  logic [DEC_N-1:0] m_dmask = '0;
  logic [RNG_N-1:0] m_rmask = '0;
  logic             m_excl = 1'b0;

  logic  pend_valid = 1'b0;
  logic  pend_exp = 1'b0;
  string pend_req = "";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fifo_stall_gate i_fifo_stall_gate (.*);

  function automatic logic exp_stall(logic [LVL_W-1:0] fr, logic [DEC_N-1:0] dm, logic [RNG_N-1:0] rm);
    logic hit;
    hit = (|(dm & m_dmask)) | (|(rm & m_rmask));
    return (fr < m_level) && (m_excl ? !hit : hit);
  endfunction

  task automatic check(logic act, logic exp, string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: stall_o actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle; the result is checked at the next step
  task automatic step(logic [LVL_W-1:0] fr, logic [DEC_N-1:0] dm, logic [RNG_N-1:0] rm,
                      logic we, logic ad, logic [CFG_W-1:0] wd, string req);
    @(negedge clk_i);
    if (pend_valid) check(stall_o, pend_exp, pend_req);
    free_bytes_i = fr; dec_match_i = dm; rng_match_i = rm;
    cfg_we_i = we; cfg_addr_i = ad; cfg_wdata_i = wd;
    pend_exp = exp_stall(fr, dm, rm);
    pend_req = req;
    pend_valid = 1'b1;
    if (we) begin
      if (ad) m_level = wd[LVL_W-1:0];
      else begin
        m_dmask = wd[15:0]; m_rmask = wd[23:16]; m_excl = wd[24];
      end
    end
  endtask

  function automatic logic [CFG_W-1:0] region_word(logic excl, logic [RNG_N-1:0] rm, logic [DEC_N-1:0] dm);
    return {excl, rm, dm};
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    // R1: reset holds output low, even with inputs that would stall later
    free_bytes_i = '0; dec_match_i = '1; rng_match_i = '1;
    #(CLK_PERIOD*3 + 1);
    check(stall_o, 1'b0, "R1");
    @(negedge clk_i); rst_ni = 1'b1;
    // R1/R3: reset configuration gives no stall
    step(8'd0, '1, '1, 1'b0, 1'b0, '0, "R1");
    step(8'd0, '1, '1, 1'b0, 1'b0, '0, "R3");
    // R3: zero level, exclude mode, no hits
    step(8'd0, '0, '0, 1'b1, 1'b0, region_word(1'b1, '0, '0), "R8");
    step(8'd0, '0, '0, 1'b0, 1'b0, '0, "R3");
    // R9: level 20 with high junk bits ignored
    step(8'd0, '0, '0, 1'b1, 1'b1, {17'h1FFFF, 8'd20}, "R9");
    step(8'd19, '0, '0, 1'b0, 1'b0, '0, "R9");
    step(8'd20, '0, '0, 1'b0, 1'b0, '0, "R2");
    step(8'd19, '0, '0, 1'b0, 1'b0, '0, "R2");
    // R5: exclude, selected decoder 3 blocks
    step(8'd0, '0, '0, 1'b1, 1'b0, region_word(1'b1, 8'h10, 16'h0004), "R8");
    step(8'd5, 16'h0004, '0, 1'b0, 1'b0, '0, "R5");
    step(8'd5, '0, 8'h10, 1'b0, 1'b0, '0, "R5");
    // R6: unselected hits ignored in exclude mode
    step(8'd5, 16'hFFFB, 8'hEF, 1'b0, 1'b0, '0, "R6");
    // R4: include mode
    step(8'd0, '0, '0, 1'b1, 1'b0, region_word(1'b0, 8'h01, 16'h8000), "R8");
    step(8'd5, 16'h8000, '0, 1'b0, 1'b0, '0, "R4");
    step(8'd5, '0, 8'h01, 1'b0, 1'b0, '0, "R4");
    step(8'd5, 16'h7FFF, 8'hFE, 1'b0, 1'b0, '0, "R6");
    step(8'd25, 16'h8000, '0, 1'b0, 1'b0, '0, "R4");
    // R10: strobe low, junk data at both addresses
    step(8'd5, 16'h8000, '0, 1'b0, 1'b1, '0, "R10");
    step(8'd5, 16'h8000, '0, 1'b0, 1'b0, region_word(1'b1, '0, '0), "R10");
    step(8'd5, 16'h8000, '0, 1'b0, 1'b0, '0, "R10");
    // R7: output follows each cycle's inputs one cycle later
    step(8'd5, '0, '0, 1'b0, 1'b0, '0, "R7");
    step(8'd5, 16'h8000, '0, 1'b0, 1'b0, '0, "R7");
    step(8'd5, '0, '0, 1'b0, 1'b0, '0, "R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic we; logic ad; logic [CFG_W-1:0] wd;
      we = ($urandom_range(0, 7) == 0);
      ad = $urandom_range(0, 1);
      wd = CFG_W'($urandom);
      if (!ad) wd = region_word(wd[24], 8'(1 << $urandom_range(0, 7)) | 8'($urandom & $urandom),
                                16'(1 << $urandom_range(0, 15)) | 16'($urandom & $urandom & $urandom));
      step(8'($urandom_range(0, 63)), 16'($urandom & $urandom & $urandom),
           8'($urandom & $urandom), we, ad, wd, "R7");
    end
    step('0, '0, '0, 1'b0, 1'b0, '0, "R7");
    @(negedge clk_i);
    check(stall_o, pend_exp, pend_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule